// File: doc/BRIEF.md
# Interleaved SAR Section Sequencer

This block is the digital timing controller for one channel of a time-interleaved converter. The channel is built from eight successive-approximation sections. A single counter, clocked by the input clock, defines a 16-clock cycle. Each section follows the same 16-slot schedule, and each section is offset by two clocks from the section before it. As a result, exactly one section takes an input sample on every second clock, so the channel samples at half the clock rate.

Each section has its own schedule slots:

- a strobe for sampling the reference zero;
- a strobe for the offset-nulling comparison;
- a strobe for the gain-trim comparison;
- a strobe for taking the input sample;
- eleven slots that resolve an 11-bit successive-approximation word, MSB first, from that section's comparator decision;
- a final slot that hands the result to an 8:1 output multiplexer.

The analog comparators and capacitor arrays sit outside this block. They consume the strobes and the trial words, and they return one decision bit per section.

A synchronous active-low reset realigns every section. The first input sample is taken in the first clock cycle after reset is released. A section's result reaches the output twelve clocks after that section sampled.

Top module: `ilv_sar_sequencer`

## Requirements
- R1: Every section repeats a 16-clock schedule. Its phase p (0..15) selects one slot: p=0 zero-reference strobe, p=1 offset-null strobe, p=2 gain-trim strobe, p=3 input-sample strobe, p=4..14 conversion, and p=15 transfer strobe. The schedule then wraps back to p=0.
- R2: When a section samples (p=3), its trial word becomes 0x400 at the end of that cycle. For each conversion phase p, bit b=14-p is the bit under trial, so the MSB comes first. At the end of that cycle, bit b takes the section's comparator decision, and bit b-1 (if b>0) is set to 1 as the next trial bit.
- R3: In the transfer phase (p=15), the output data equals that section's fully resolved 11-bit word.
- R4: The phase of section s is the phase of section 0 minus 2·s, modulo 16.
- R5: While running, exactly one input-sample strobe is active on every second clock, and none is active on the clocks in between.
- R6: out_valid is high exactly when a primed section is in its transfer phase. At that time out_sec gives the index of that section. While out_valid is low, out_data is 0.
- R7: While rst_n is low at a clock edge, all strobes are low in the following cycle. In the first cycle after the first edge with rst_n high, section 0 raises its input-sample strobe and no other section does.
- R8: After reset, a section does not produce out_valid in a transfer phase until it has taken an input sample.
- R9: A section's comparator decision has no effect on its trial word outside that section's conversion phases.
- R10: No section raises more than one of its five strobes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all sequencing happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low realignment reset |
| cmp_dec | input | 8 | Comparator decision, one bit per section |
| zero_stb | output | 8 | Zero-reference sampling strobe per section |
| azero_stb | output | 8 | Offset-null comparison strobe per section |
| gcal_stb | output | 8 | Gain-trim comparison strobe per section |
| smp_stb | output | 8 | Input-sample strobe per section |
| xfer_stb | output | 8 | Result transfer strobe per section |
| sar_words | output | 88 | Trial words, section s in bits [11s+10:11s] |
| out_data | output | 11 | Multiplexed result of the transferring section |
| out_valid | output | 1 | Result on out_data is valid |
| out_sec | output | 3 | Index of the transferring section |

## Verification
The bench targets the start-up window after reset. In that window, sections 2 to 7 pass through their transfer slot before they have ever sampled. A design without per-section priming would flag stale words as valid. A design that loaded the counter with the wrong value would put the first sample strobe on the wrong clock or on the wrong section. The bench applies reset both in mid-stream and for a single cycle; an off-by-one slot decode would shift every strobe and would corrupt the LSB or keep stray comparator bits. Runs with comparator inputs held all-ones and all-zeros check the resolved extremes 0x7FF and 0x000. Random decisions that keep toggling outside the conversion slots expose a register that listens to its comparator at the wrong time.

// File: rtl/ilv_sar_pkg.sv
// Package: shared slot encoding and the slot decode used by every section.
// Assumes the input-sample slot sits at phase 3 and conversion follows it directly.
package ilv_sar_pkg;

    typedef enum logic [2:0] {
        SLOT_ZERO,
        SLOT_AZERO,
        SLOT_GCAL,
        SLOT_SAMPLE,
        SLOT_CONV,
        SLOT_XFER,
        SLOT_IDLE
    } slot_e;

    localparam int SLOT_SAMPLE_PH = 3;

    // Map a section phase to its schedule slot for a given word width.
    function automatic slot_e slot_of(input int ph, input int sar_w);
        if (ph == 0) begin
            return SLOT_ZERO;
        end else if (ph == 1) begin
            return SLOT_AZERO;
        end else if (ph == 2) begin
            return SLOT_GCAL;
        end else if (ph == SLOT_SAMPLE_PH) begin
            return SLOT_SAMPLE;
        end else if (ph <= SLOT_SAMPLE_PH + sar_w) begin
            return SLOT_CONV;
        end else if (ph == SLOT_SAMPLE_PH + sar_w + 1) begin
            return SLOT_XFER;
        end else begin
            return SLOT_IDLE;
        end
    endfunction

endpackage

// File: rtl/ilv_phase_gen.sv
// Master phase counter shared by all sections.
// Reset loads the value one below the sample slot, so section 0 samples
// in the first cycle after release. PHASES must be a power of two.
module ilv_phase_gen
    import ilv_sar_pkg::*;
#(
    parameter int PHASES = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic [$clog2(PHASES)-1:0]   cnt_o,
    output logic                        run_o
);

    localparam int PH_W = $clog2(PHASES);
    localparam logic [PH_W-1:0] RST_CNT = PH_W'(SLOT_SAMPLE_PH - 1);

    logic [PH_W-1:0] cnt_q;
    logic            run_q;

    if (PHASES != (1 << PH_W)) begin : g_bad_phases
        $error("PHASES must be a power of two");
    end

    // Advance the shared phase each clock; hold the preload during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_CNT;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            run_q <= 1'b1;
        end
    end

    assign cnt_o = cnt_q;
    assign run_o = run_q;

    // R1: the phase steps by one each running clock, wrapping modulo PHASES.
    assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> (cnt_q == PH_W'($past(cnt_q) + 1'b1)));

    // R7: the first running cycle is the sample phase of section 0.
    assert_first_run_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> (run_q && cnt_q == PH_W'(SLOT_SAMPLE_PH)));

endmodule

// File: rtl/ilv_sar_section.sv
// One converter section: it decodes its own phase from the shared counter,
// drives its five slot strobes, and holds its successive-approximation word.
// Assumes the conversion slots immediately follow the sample slot.
module ilv_sar_section
    import ilv_sar_pkg::*;
#(
    parameter int SEC_IDX = 0,
    parameter int PHASES  = 16,
    parameter int STAGGER = 2,
    parameter int SAR_W   = 11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run_i,
    input  logic [$clog2(PHASES)-1:0]   cnt_i,
    input  logic                        cmp_i,
    output logic                        zero_o,
    output logic                        azero_o,
    output logic                        gcal_o,
    output logic                        smp_o,
    output logic                        xfer_o,
    output logic [SAR_W-1:0]            word_o,
    output logic                        primed_o
);

    localparam int PH_W  = $clog2(PHASES);
    localparam int BIT_W = $clog2(SAR_W);
    localparam int CONV0 = SLOT_SAMPLE_PH + 1;
    localparam logic [PH_W-1:0]  OFFSET   = PH_W'(STAGGER * SEC_IDX);
    localparam logic [SAR_W-1:0] MSB_ONLY = {1'b1, {(SAR_W-1){1'b0}}};

    logic [PH_W-1:0]  ph;
    slot_e            slot;
    logic [BIT_W-1:0] bit_pos;
    logic [SAR_W-1:0] word_q;
    logic             primed_q;

    // Phase of this section and its current slot (idle while not running).
    always_comb begin
        ph      = cnt_i - OFFSET;
        slot    = run_i ? slot_of(int'(ph), SAR_W) : SLOT_IDLE;
        bit_pos = BIT_W'(SAR_W - 1 - (int'(ph) - CONV0));
    end

    // Slot strobes for the analog side.
    assign zero_o  = (slot == SLOT_ZERO);
    assign azero_o = (slot == SLOT_AZERO);
    assign gcal_o  = (slot == SLOT_GCAL);
    assign smp_o   = (slot == SLOT_SAMPLE);
    assign xfer_o  = (slot == SLOT_XFER);

    // Successive approximation: load the MSB trial, then resolve one bit per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            primed_q <= 1'b0;
        end else if (slot == SLOT_SAMPLE) begin
            word_q   <= MSB_ONLY;
            primed_q <= 1'b1;
        end else if (slot == SLOT_CONV) begin
            word_q[bit_pos] <= cmp_i;
            if (bit_pos != '0) begin
                word_q[bit_pos - 1'b1] <= 1'b1;
            end
        end
    end

    assign word_o   = word_q;
    assign primed_o = primed_q;

    // R1: gain trim is always followed by the input sample.
    assert_cal_then_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
        gcal_o |=> smp_o);

    // R1: after transfer the schedule wraps to the zero-reference slot.
    assert_xfer_then_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |=> zero_o);

    // R2: sampling leaves only the MSB trial bit set.
    assert_sample_loads_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_o |=> (word_q == MSB_ONLY));

    // R9: outside sample and conversion, the word does not move.
    assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && slot != SLOT_CONV && slot != SLOT_SAMPLE) |=> $stable(word_q));

    // R10: at most one strobe per section per cycle.
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({zero_o, azero_o, gcal_o, smp_o, xfer_o}) <= 1);

endmodule

// File: rtl/ilv_xfer_mux.sv
// Output selector: it passes the word of the primed section in transfer.
// Assumes at most one section is in its transfer slot at any time.
module ilv_xfer_mux #(
    parameter int NUM_SEC = 8,
    parameter int SAR_W   = 11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SEC-1:0]          xfer_i,
    input  logic [NUM_SEC-1:0]          primed_i,
    input  logic [NUM_SEC*SAR_W-1:0]    words_i,
    output logic [SAR_W-1:0]            data_o,
    output logic                        valid_o,
    output logic [$clog2(NUM_SEC)-1:0]  sec_o
);

    localparam int SEL_W = $clog2(NUM_SEC);

    // Pick the transferring primed section; drive zero otherwise.
    always_comb begin
        data_o  = '0;
        valid_o = 1'b0;
        sec_o   = '0;
        for (int s = 0; s < NUM_SEC; s++) begin
            if (xfer_i[s] && primed_i[s]) begin
                data_o  = words_i[s*SAR_W +: SAR_W];
                valid_o = 1'b1;
                sec_o   = SEL_W'(s);
            end
        end
    end

    // R6: never two sections in transfer at once.
    assert_single_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xfer_i));

    // R5: transfers, like samples, fall on alternate clocks.
    assert_xfer_alternate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|xfer_i) |=> !(|xfer_i));

endmodule

// File: rtl/ilv_sar_sequencer.sv
// Top: shared phase counter, NUM_SEC staggered sections and the output mux.
// Assumes NUM_SEC*STAGGER equals the schedule length and the schedule fits.
module ilv_sar_sequencer
    import ilv_sar_pkg::*;
#(
    parameter int NUM_SEC = 8,
    parameter int SAR_W   = 11,
    parameter int STAGGER = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SEC-1:0]           cmp_dec,
    output logic [NUM_SEC-1:0]           zero_stb,
    output logic [NUM_SEC-1:0]           azero_stb,
    output logic [NUM_SEC-1:0]           gcal_stb,
    output logic [NUM_SEC-1:0]           smp_stb,
    output logic [NUM_SEC-1:0]           xfer_stb,
    output logic [NUM_SEC*SAR_W-1:0]     sar_words,
    output logic [SAR_W-1:0]             out_data,
    output logic                         out_valid,
    output logic [$clog2(NUM_SEC)-1:0]   out_sec
);

    localparam int PHASES = NUM_SEC * STAGGER;
    localparam int PH_W   = $clog2(PHASES);

    logic [PH_W-1:0]    cnt;
    logic               run;
    logic [NUM_SEC-1:0] primed;

    if (SLOT_SAMPLE_PH + SAR_W + 2 > PHASES) begin : g_bad_fit
        $error("schedule does not fit in NUM_SEC*STAGGER phases");
    end

    ilv_phase_gen #(
        .PHASES (PHASES)
    ) i_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt),
        .run_o (run)
    );

    for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
        ilv_sar_section #(
            .SEC_IDX (s),
            .PHASES  (PHASES),
            .STAGGER (STAGGER),
            .SAR_W   (SAR_W)
        ) i_sec (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_i    (run),
            .cnt_i    (cnt),
            .cmp_i    (cmp_dec[s]),
            .zero_o   (zero_stb[s]),
            .azero_o  (azero_stb[s]),
            .gcal_o   (gcal_stb[s]),
            .smp_o    (smp_stb[s]),
            .xfer_o   (xfer_stb[s]),
            .word_o   (sar_words[s*SAR_W +: SAR_W]),
            .primed_o (primed[s])
        );

        // R4: the next section samples STAGGER clocks later.
        assert_stagger_R4: assert property (@(posedge clk) disable iff (!rst_n)
            smp_stb[s] |=> ##1 smp_stb[(s + 1) % NUM_SEC]);
    end

    ilv_xfer_mux #(
        .NUM_SEC (NUM_SEC),
        .SAR_W   (SAR_W)
    ) i_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer_i   (xfer_stb),
        .primed_i (primed),
        .words_i  (sar_words),
        .data_o   (out_data),
        .valid_o  (out_valid),
        .sec_o    (out_sec)
    );

    // R5: never more than one section sampling.
    assert_one_sampler_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(smp_stb));

    // R5: a running clock with no sample is followed by one with a sample.
    assert_sample_cadence_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(|smp_stb)) |=> (|smp_stb));

    // R8: a valid output comes only from a section in transfer.
    assert_valid_needs_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> xfer_stb[out_sec]);

endmodule

// File: tb/test_ilv_sar_sequencer.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the staggered schedule and the SAR
// words, compared with every output on every clock.
module test_ilv_sar_sequencer;

    localparam int NS = 8;
    localparam int W  = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     cmp = '0;
    logic [NS-1:0]     zero_stb, azero_stb, gcal_stb, smp_stb, xfer_stb;
    logic [NS*W-1:0]   sar_words;
    logic [W-1:0]      out_data;
    logic              out_valid;
    logic [2:0]        out_sec;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference model state.
    bit m_run = 0;
    int k = 0;
    int m_sar [NS];
    bit m_primed [NS];

    ilv_sar_sequencer i_ilv_sar_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_dec   (cmp),
        .zero_stb  (zero_stb),
        .azero_stb (azero_stb),
        .gcal_stb  (gcal_stb),
        .smp_stb   (smp_stb),
        .xfer_stb  (xfer_stb),
        .sar_words (sar_words),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_sec   (out_sec)
    );

    always #2 clk = ~clk;

    function automatic int phase_of(int s);
        return ((3 + k - 2 * s) % 16 + 16) % 16;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        int exp_valid = 0;
        int exp_data = 0;
        int exp_sec = 0;
        bit unprimed_xfer = 0;
        for (int s = 0; s < NS; s++) begin
            int ph = m_run ? phase_of(s) : -1;
            int prev = (ph + 15) % 16;
            logic [4:0] act_stb = {zero_stb[s], azero_stb[s], gcal_stb[s], smp_stb[s], xfer_stb[s]};
            logic [4:0] exp_stb = {ph == 0, ph == 1, ph == 2, ph == 3, ph == 15};
            string tag = !m_run ? "R7" : (s == 0 ? "R1" : "R4");
            check(tag, int'(act_stb), int'(exp_stb));
            check("R10", int'($countones(act_stb) <= 1), 1);
            // The word now reflects the previous phase: R2 when that phase was
            // sample or conversion, R9 when the comparator had to be ignored.
            check((m_run && prev >= 3 && prev <= 14) ? "R2" : "R9",
                  int'(sar_words[s*W +: W]), m_sar[s]);
            if (ph == 15) begin
                if (m_primed[s]) begin
                    exp_valid = 1;
                    exp_data = m_sar[s];
                    exp_sec = s;
                end else begin
                    unprimed_xfer = 1;
                end
            end
        end
        check("R5", $countones(smp_stb), (m_run && (k % 2 == 0)) ? 1 : 0);
        if (m_run && k == 0) check("R7", int'(smp_stb), 1);
        check(unprimed_xfer ? "R8" : "R6", int'(out_valid), exp_valid);
        if (exp_valid != 0) begin
            check("R3", int'(out_data), exp_data);
            check("R6", int'(out_sec), exp_sec);
        end else begin
            check("R6", int'(out_data), 0);
        end
    endtask

    task automatic model_step(logic rst_v, logic [NS-1:0] cmp_v);
        if (!rst_v) begin
            m_run = 0;
            k = 0;
            for (int s = 0; s < NS; s++) begin
                m_sar[s] = 0;
                m_primed[s] = 0;
            end
        end else if (!m_run) begin
            m_run = 1;
            k = 0;
        end else begin
            for (int s = 0; s < NS; s++) begin
                int ph = phase_of(s);
                if (ph == 3) begin
                    m_sar[s] = 1 << (W - 1);
                    m_primed[s] = 1;
                end else if (ph >= 4 && ph <= 14) begin
                    int b = 14 - ph;
                    if (cmp_v[s]) m_sar[s] = m_sar[s] | (1 << b);
                    else          m_sar[s] = m_sar[s] & ~(1 << b);
                    if (b > 0) m_sar[s] = m_sar[s] | (1 << (b - 1));
                end
            end
            k++;
        end
    endtask

    task automatic cycle_step(logic rst_v, logic [NS-1:0] cmp_v);
        @(negedge clk);
        rst_n = rst_v;
        cmp = cmp_v;
        #1;
        check_outputs();
        model_step(rst_v, cmp_v);
    endtask

    initial begin
        for (int s = 0; s < NS; s++) begin
            m_sar[s] = 0;
            m_primed[s] = 0;
        end
        // Reset state and release (R7).
        repeat (3) cycle_step(1'b0, '0);
        // Random decisions, including start-up unprimed transfers (R8).
        for (int i = 0; i < 200; i++) cycle_step(1'b1, NS'($urandom));
        // All-ones decisions resolve 0x7FF (R2, R3).
        for (int i = 0; i < 40; i++) cycle_step(1'b1, '1);
        // All-zeros decisions resolve 0x000.
        for (int i = 0; i < 40; i++) cycle_step(1'b1, '0);
        // Mid-stream reset realigns the phases.
        repeat (3) cycle_step(1'b0, NS'($urandom));
        for (int i = 0; i < 60; i++) cycle_step(1'b1, NS'($urandom));
        // Single-cycle reset pulse.
        cycle_step(1'b0, '1);
        for (int i = 0; i < 80; i++) cycle_step(1'b1, NS'($urandom));
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #80000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule